// File: doc/BRIEF.md
# Real-Time Counter Interrupt Flag Controller

This block keeps the interrupt status of a real-time counter and produces that counter's interrupt request. Everything runs on the counter clock. Three kinds of event reach it. The first is a free-running prescaler value. A rising edge on one of eight consecutive prescaler taps marks the end of a periodic interval. The second is a one-cycle overflow strobe. The third is a one-cycle compare-match (alarm) strobe. Each event latches a sticky flag, which becomes visible one counter-clock cycle after the event.

Software reaches the block through a simple register port. Writes take effect at the clock edge and reads are combinational. Through this port software reads the flags and clears them by writing ones. It builds an enable mask through separate set and clear addresses. The single interrupt output is a level. It stays high while any flag whose enable is on remains set.

Top module: `rtc_irq_flags`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), the flag register and the enable mask read 0x0000 and irq is low.
- R2: Byte address 0x0C returns the flags: periodic flags 0..7 on bits 0..7, alarm on bit 8, overflow on bit 15, with all other bits reading 0. Addresses 0x0A and 0x08 both return the enable mask, using the same bit layout. Any other address reads 0x0000.
- R3: If ovf_pulse is high in a cycle, bit 15 of the flag register reads 1 from the following cycle onward, and not before.
- R4: If cmp_match is high in a cycle, bit 8 of the flag register reads 1 from the following cycle onward, and not before.
- R5: Periodic flag n (bit n) is set in the cycle after prescaler bit n+2 is sampled as 1 when it was 0 at the previous edge. The previous value is also captured during reset. Falling edges and changes on other prescaler bits set nothing.
- R6: A write to 0x0C clears every flag whose bit in the written data is 1. Zero bits, reserved bits and writes to other addresses leave the flags unchanged.
- R7: If an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: A write to 0x0A sets the enable bits written as 1. A write to 0x08 clears the enable bits written as 1. Zero bits leave enables unchanged.
- R9: irq is high exactly while some flag and its enable are both 1. Flags keep their state while disabled, so enabling an already-set flag raises irq in the cycle after the enable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| presc | input | PRESC_W (12) | Free-running prescaler value |
| ovf_pulse | input | 1 | Counter overflow strobe |
| cmp_match | input | 1 | Compare-match (alarm) strobe |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check several rules on every cycle. Each event must produce its flag at the next edge. A clear with no competing event must drop the flag. A flag must hold when neither an event nor a clear touches it. Each prescaler rise must yield an edge pulse, enable writes must act on the next edge, and irq must stay low while the mask is empty. Some behaviours can only be shown by the bench's scenarios, which compare the readback against an independent model. These are: the one-cycle lag seen at the register port, the bit layout and reserved bits, silence on falling prescaler edges, the set-over-clear rule, and the way irq follows the enable mask while flags persist.

// File: rtl/rtc_irq_pkg.sv
// Shared register offsets and bit positions of the interrupt flag controller.
// Assumes a 16-bit register port addressed in bytes.
package rtc_irq_pkg;
    localparam int REG_AW    = 8;
    localparam int REG_DW    = 16;
    localparam logic [REG_AW-1:0] OFF_EN_CLR = 8'h08;
    localparam logic [REG_AW-1:0] OFF_EN_SET = 8'h0A;
    localparam logic [REG_AW-1:0] OFF_FLAGS  = 8'h0C;
    localparam int BIT_ALARM = 8;
    localparam int BIT_OVF   = 15;
endpackage

// File: rtl/rtc_presc_edge.sv
// Detects 0-to-1 transitions on NUM_PER consecutive prescaler taps starting at
// bit PER_BASE. Assumes PER_BASE+NUM_PER <= PRESC_W. The previous tap value is
// captured while reset is held, so releasing reset never fakes an edge.
module rtc_presc_edge #(
    parameter int PRESC_W  = 12,
    parameter int NUM_PER  = 8,
    parameter int PER_BASE = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] presc,
    output logic [NUM_PER-1:0] rise
);
    localparam int TOP = PER_BASE + NUM_PER - 1;

    logic [NUM_PER-1:0] taps;
    logic [NUM_PER-1:0] taps_q;
    wire  unused_presc = ^presc;

    assign taps = presc[TOP:PER_BASE];

    // Remember the tap values seen at the previous edge (also during reset).
    always_ff @(posedge clk) begin
        taps_q <= taps;
    end

    genvar k;
    generate
        for (k = 0; k < NUM_PER; k++) begin : g_tap
            assign rise[k] = taps[k] & ~taps_q[k];

            // R5: a sampled rise on a tap must produce its edge pulse.
            a_r5_tap_rise : assert property (@(posedge clk) disable iff (!rst_n)
                $rose(presc[PER_BASE+k]) |-> rise[k]);
        end
    endgenerate
endmodule

// File: rtl/rtc_flag_bank.sv
// Bank of W sticky flags. An event sets its flag at the next edge. A clear
// request drops it, but an event in the same cycle wins.
// Assumes set_i and clr_i are single-cycle requests on the same clock.
module rtc_flag_bank #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q
);
    // Update every flag: clear requested bits, then let events win.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr_i) | set_i;
    end

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_chk
            // R3: an event shows as a set flag in the next cycle.
            a_r3_set_next : assert property (@(posedge clk) disable iff (!rst_n)
                set_i[i] |=> q[i]);
            // R6: a clear with no competing event drops the flag.
            a_r6_clear : assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[i] && !set_i[i]) |=> !q[i]);
            // R6: an untouched flag holds its value.
            a_r6_hold : assert property (@(posedge clk) disable iff (!rst_n)
                (!clr_i[i] && !set_i[i]) |=> $stable(q[i]));
        end
    endgenerate
endmodule

// File: rtl/rtc_irq_enable.sv
// Enable mask with separate write-one-to-set and write-one-to-clear inputs.
// Assumes the two inputs come from different addresses and never act together.
module rtc_irq_enable #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q
);
    // Apply set and clear requests to the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q | set_i) & ~clr_i;
    end

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_chk
            // R8: a set request turns the enable on at the next edge.
            a_r8_en_set : assert property (@(posedge clk) disable iff (!rst_n)
                (set_i[i] && !clr_i[i]) |=> q[i]);
            // R8: a clear request turns the enable off at the next edge.
            a_r8_en_clr : assert property (@(posedge clk) disable iff (!rst_n)
                clr_i[i] |=> !q[i]);
        end
    endgenerate
endmodule

// File: rtl/rtc_irq_flags.sv
// Interrupt flag controller of a real-time counter. It latches periodic,
// alarm and overflow events, exposes them through a 16-bit register port
// with write-one-to-clear flags and set/clear enables, and drives a level
// interrupt. Assumes all inputs are synchronous to clk.
module rtc_irq_flags
    import rtc_irq_pkg::*;
#(
    parameter int PRESC_W  = 12,
    parameter int NUM_PER  = 8,
    parameter int PER_BASE = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] presc,
    input  logic               ovf_pulse,
    input  logic               cmp_match,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic               reg_we,
    input  logic [REG_DW-1:0]  reg_wdata,
    output logic [REG_DW-1:0]  reg_rdata,
    output logic               irq
);
    localparam int NF      = NUM_PER + 2;
    localparam int IDX_ALM = NUM_PER;
    localparam int IDX_OVF = NUM_PER + 1;

    logic [NUM_PER-1:0] per_rise;
    logic [NF-1:0]      evt;
    logic [NF-1:0]      wbits;
    logic [NF-1:0]      flag_clr, en_set, en_clr;
    logic [NF-1:0]      flags, en;
    logic [REG_DW-1:0]  flags_bus, en_bus;
    wire                unused_wdata = ^reg_wdata;

    rtc_presc_edge #(.PRESC_W(PRESC_W), .NUM_PER(NUM_PER), .PER_BASE(PER_BASE)) u_edge (
        .clk(clk), .rst_n(rst_n), .presc(presc), .rise(per_rise)
    );

    assign evt = {ovf_pulse, cmp_match, per_rise};

    // Gather written data into the internal flag order.
    always_comb begin
        wbits                = '0;
        wbits[NUM_PER-1:0]   = reg_wdata[NUM_PER-1:0];
        wbits[IDX_ALM]       = reg_wdata[BIT_ALARM];
        wbits[IDX_OVF]       = reg_wdata[BIT_OVF];
    end

    // Decode the three writable addresses into request vectors.
    always_comb begin
        flag_clr = (reg_we && reg_addr == OFF_FLAGS)  ? wbits : '0;
        en_set   = (reg_we && reg_addr == OFF_EN_SET) ? wbits : '0;
        en_clr   = (reg_we && reg_addr == OFF_EN_CLR) ? wbits : '0;
    end

    rtc_flag_bank #(.W(NF)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(evt), .clr_i(flag_clr), .q(flags)
    );

    rtc_irq_enable #(.W(NF)) u_en (
        .clk(clk), .rst_n(rst_n), .set_i(en_set), .clr_i(en_clr), .q(en)
    );

    // Place internal flags and enables at their register bit positions.
    always_comb begin
        flags_bus                 = '0;
        flags_bus[NUM_PER-1:0]    = flags[NUM_PER-1:0];
        flags_bus[BIT_ALARM]      = flags[IDX_ALM];
        flags_bus[BIT_OVF]        = flags[IDX_OVF];
        en_bus                    = '0;
        en_bus[NUM_PER-1:0]       = en[NUM_PER-1:0];
        en_bus[BIT_ALARM]         = en[IDX_ALM];
        en_bus[BIT_OVF]           = en[IDX_OVF];
    end

    // Read multiplexer over the register map.
    always_comb begin
        case (reg_addr)
            OFF_FLAGS:              reg_rdata = flags_bus;
            OFF_EN_SET, OFF_EN_CLR: reg_rdata = en_bus;
            default:                reg_rdata = '0;
        endcase
    end

    assign irq = |(flags & en);

    // R9: with every enable off the request must stay low.
    a_r9_masked_quiet : assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq);
    // R2: reserved positions of the flag register read as zero.
    a_r2_reserved_zero : assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_FLAGS) |-> (reg_rdata[14:9] == '0));
    // R1: the cycle after reset the flags are empty.
    a_r1_reset_clean : assert property (@(posedge clk)
        !rst_n |=> (flags == '0 && en == '0));
endmodule

// File: tb/sim_rtc_irq_flags.sv
// Self-checking bench: directed corner cases followed by seeded random traffic,
// compared against a register-level model computed from the requirements.
module sim_rtc_irq_flags;
    localparam logic [15:0] MASK = 16'h81FF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] presc;
    logic        ovf_pulse, cmp_match;
    logic [7:0]  reg_addr;
    logic        reg_we;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    logic [15:0] m_flag, m_en;
    logic [11:0] m_prev;

    always #10 clk = ~clk;

    rtc_irq_flags u0 (
        .clk(clk), .rst_n(rst_n), .presc(presc), .ovf_pulse(ovf_pulse),
        .cmp_match(cmp_match), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [15:0] evt_bits(logic [11:0] prev, logic [11:0] cur,
                                             logic o, logic c);
        logic [15:0] b = '0;
        for (int n = 0; n < 8; n++) b[n] = cur[n+2] & ~prev[n+2];
        b[8]  = c;
        b[15] = o;
        return b;
    endfunction

    function automatic logic [15:0] exp_read(logic [7:0] a);
        if (a == 8'h0C) return m_flag;
        if (a == 8'h08 || a == 8'h0A) return m_en;
        return 16'h0000;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock cycle with the given inputs; the model follows the edge.
    task automatic cyc(logic [11:0] p, logic o, logic c, logic [7:0] a,
                       logic we, logic [15:0] wd);
        logic [15:0] nf, ne;
        presc = p; ovf_pulse = o; cmp_match = c;
        reg_addr = a; reg_we = we; reg_wdata = wd;
        nf = m_flag;
        if (we && a == 8'h0C) nf = nf & ~(wd & MASK);
        nf = nf | evt_bits(m_prev, p, o, c);
        ne = m_en;
        if (we && a == 8'h0A) ne = ne | (wd & MASK);
        if (we && a == 8'h08) ne = ne & ~(wd & MASK);
        @(posedge clk);
        @(negedge clk);
        m_flag = nf; m_en = ne; m_prev = p;
        ovf_pulse = 1'b0; cmp_match = 1'b0; reg_we = 1'b0;
        #1;
        check("R9 irq", {15'd0, irq}, {15'd0, |(m_flag & m_en)});
    endtask

    task automatic rd(logic [7:0] a, string req);
        reg_we = 1'b0; reg_addr = a;
        #1;
        check(req, reg_rdata, exp_read(a));
    endtask

    task automatic idle();
        cyc(presc, 1'b0, 1'b0, 8'h00, 1'b0, 16'h0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [11:0] p;
        void'($urandom(32'd1234));
        rst_n = 1'b0; presc = 12'h000; ovf_pulse = 1'b0; cmp_match = 1'b0;
        reg_addr = 8'h00; reg_we = 1'b0; reg_wdata = 16'h0;
        m_flag = 16'h0; m_en = 16'h0; m_prev = 12'h000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h0C, "R1 flags"); check("R1 flags literal", reg_rdata, 16'h0000);
        rd(8'h0A, "R1 enables");
        check("R1 irq", {15'd0, irq}, 16'h0);

        // R3: overflow visible only after the edge
        presc = 12'h000; reg_addr = 8'h0C; ovf_pulse = 1'b1; #1;
        check("R3 not yet", reg_rdata, 16'h0000);
        cyc(12'h000, 1'b1, 1'b0, 8'h0C, 1'b0, 16'h0);
        rd(8'h0C, "R3 ovf"); check("R3 literal", reg_rdata, 16'h8000);

        // R4: alarm visible only after the edge
        reg_addr = 8'h0C; cmp_match = 1'b1; #1;
        check("R4 not yet", reg_rdata, 16'h8000);
        cyc(12'h000, 1'b0, 1'b1, 8'h0C, 1'b0, 16'h0);
        rd(8'h0C, "R4 alarm"); check("R4 literal", reg_rdata, 16'h8100);

        // R6: zeros, reserved bits and other addresses do nothing
        cyc(12'h000, 1'b0, 1'b0, 8'h0C, 1'b1, 16'h7E00);
        rd(8'h0C, "R6 reserved write");
        cyc(12'h000, 1'b0, 1'b0, 8'h04, 1'b1, 16'hFFFF);
        rd(8'h0C, "R6 other address");
        rd(8'h04, "R2 unmapped reads zero");
        cyc(12'h000, 1'b0, 1'b0, 8'h0C, 1'b1, 16'h0100);
        rd(8'h0C, "R6 clear alarm"); check("R6 literal", reg_rdata, 16'h8000);

        // R5: single tap rise, falling edge, all taps
        cyc(12'h004, 1'b0, 1'b0, 8'h00, 1'b0, 16'h0);
        rd(8'h0C, "R5 tap0 rise"); check("R5 literal", reg_rdata, 16'h8001);
        cyc(12'h003, 1'b0, 1'b0, 8'h0C, 1'b1, 16'h0001);
        cyc(12'h000, 1'b0, 1'b0, 8'h00, 1'b0, 16'h0);
        rd(8'h0C, "R5 fall and low bits ignored"); check("R5 fall literal", reg_rdata, 16'h8000);
        cyc(12'h3FC, 1'b0, 1'b0, 8'h00, 1'b0, 16'h0);
        rd(8'h0C, "R5 all taps"); check("R5 all literal", reg_rdata, 16'h80FF);
        cyc(12'hC00, 1'b0, 1'b0, 8'h0C, 1'b1, 16'hFFFF);
        rd(8'h0C, "R5 top bits ignored"); check("R5 top literal", reg_rdata, 16'h0000);

        // R7: event and clear together
        cyc(12'hC00, 1'b1, 1'b1, 8'h0C, 1'b1, 16'h8100);
        rd(8'h0C, "R7 set wins"); check("R7 literal", reg_rdata, 16'h8100);

        // R8: enable set/clear
        cyc(12'hC00, 1'b0, 1'b0, 8'h0A, 1'b1, 16'h8101);
        rd(8'h0A, "R8 set"); rd(8'h08, "R2 enable alias");
        check("R8 literal", reg_rdata, 16'h8101);
        cyc(12'hC00, 1'b0, 1'b0, 8'h08, 1'b1, 16'h0000);
        rd(8'h08, "R8 zero write");
        cyc(12'hC00, 1'b0, 1'b0, 8'h08, 1'b1, 16'h8100);
        rd(8'h0A, "R8 clear"); check("R8 clear literal", reg_rdata, 16'h0001);

        // R9: disabled flags persist; enabling raises irq at once
        check("R9 disabled low", {15'd0, irq}, 16'h0);
        rd(8'h0C, "R9 flags kept");
        cyc(12'hC00, 1'b0, 1'b0, 8'h0A, 1'b1, 16'h0100);
        check("R9 enable raises", {15'd0, irq}, 16'h1);
        cyc(12'hC00, 1'b0, 1'b0, 8'h0C, 1'b1, 16'h0100);
        check("R9 clear drops", {15'd0, irq}, 16'h0);

        // Random traffic against the model (R2..R9)
        p = 12'hC00;
        for (int i = 0; i < 800; i++) begin
            logic [7:0]  a;
            logic        we;
            logic [15:0] wd;
            int sel = $urandom_range(0, 3);
            a  = (sel == 0) ? 8'h08 : (sel == 1) ? 8'h0A : (sel == 2) ? 8'h0C : 8'($urandom_range(0, 15));
            we = ($urandom_range(0, 9) < 3);
            wd = 16'($urandom);
            p  = p + 12'($urandom_range(0, 40));
            cyc(p, ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0), a, we, wd);
            rd(8'h0C, "R5/R6 random flags");
            if (i % 4 == 0) rd(8'h0A, "R8 random enables");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule